// File: doc/BRIEF.md
# Dithered Quadrature Oscillator and Complex Mixer

This block shifts a complex sample stream in frequency. A 32-bit phase accumulator advances by a programmable unsigned step on every enabled sample. The step may be changed on any clock. The frequency it produces is `phase_inc * Fs / 2^32`, so the resolution is `Fs / 2^32` and every usable frequency lies below `Fs / 2`.

The top bits of the phase address a single quarter-wave sine table. Symmetry over the four quadrants gives both a cosine and a sine sample. The mixer then multiplies the input `(i_in + j*q_in)` by `cos - j*sin` and returns rounded and saturated 16-bit I and Q with a valid pulse. For a real-only source, `q_in` is held at zero.

As a build option, a seeded 32-bit pseudo-random sequence is added to the phase bits that lie below the table address. This dithers the truncation and spreads the quantization spurs. A second option sets the table address to 12 or 16 bits. Every register advances only when `en` is high, so a low `en` freezes the whole datapath.

Top module: `nco_mixer`

## Requirements
- R1: While `rst_n` is low, asynchronously and independently of `clk`, `i_out`, `q_out` and `out_valid` are 0. The phase is cleared and the dither generator is reloaded with `SEED`, so a run after reset repeats the outputs of the first run exactly.
- R2: The phase used for an accepted sample is the modulo-2^32 sum of the `phase_inc` values accepted with all earlier samples since reset (0 for the first sample). A new step takes effect from the very next accepted sample.
- R3: When `DITHER_ON` is 1, the low `32-LUT_BITS` bits of a 32-bit generator are added to the phase before truncation. The generator starts at `SEED` and steps once per accepted sample by `s -> (s >> 1) xor (s[0] ? 32'h8020_0003 : 0)`. Its state is never zero.
- R4: The table address `a` is the top `LUT_BITS` bits of the dithered phase. The oscillator values are `c = round(32767*cos(2*pi*(a+0.5)/2^LUT_BITS))` and `s = round(32767*sin(...))`, each within 1 LSB, in all four quadrants.
- R5: Mixing gives `I = i*c + q*s` and `Q = q*c - i*s`. Each is scaled by `floor(x/2^15 + 1/2)`.
- R6: With `q_in = 0`, the outputs reduce to `I = i*c/2^15` and `Q = -i*s/2^15`, with the same rounding.
- R7: A clock with `en` low changes no state. `i_out`, `q_out` and the generator state stay unchanged and `out_valid` is 0 on the next cycle.
- R8: `out_valid` is 1 for exactly the cycle after each accepted sample, once four samples have been accepted since reset. The data shown then belongs to the sample accepted three accepted samples earlier.
- R9: Results beyond the 16-bit range saturate to 32767 or -32768 and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Sample accept; all state holds when low |
| phase_inc | input | 32 | Unsigned phase step per accepted sample |
| i_in | input | 16 | In-phase input sample, signed |
| q_in | input | 16 | Quadrature input sample, signed |
| i_out | output | 16 | Mixed in-phase result, signed |
| q_out | output | 16 | Mixed quadrature result, signed |
| out_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
A wrong accumulator or dither state is never masked. Four accepted samples later it shows as an output that drifts away from the expected rotation. An error in the dither bits shows at the first address boundary crossing, as a step of tens of LSB. A wrong quadrant or sign choice shows up as soon as the phase enters that quadrant, as a mirrored or negated I or Q value. Errors in the valid delay or the enable hold are seen on the very cycle they occur, by checking `out_valid` and the held outputs on every clock.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int unsigned LFSR_W = 32;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 32'h8020_0003;

    typedef enum logic [1:0] {
        QD_FIRST  = 2'd0,
        QD_SECOND = 2'd1,
        QD_THIRD  = 2'd2,
        QD_FOURTH = 2'd3
    } quad_e;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return (s >> 1) ^ (s[0] ? LFSR_TAPS : '0);
    endfunction

    // Quarter-wave entry k of a table with 2^lb points per turn, sampled at
    // the middle of its step, scaled by amp. Fixed-point Taylor series, Q30.
    function automatic int qsine(input int k, input int lb, input int amp);
        longint x;
        longint term;
        longint sum;
        x    = (64'sd6746518852 * longint'(2 * k + 1)) >>> (lb + 1);
        term = x;
        sum  = x;
        for (int n = 1; n <= 7; n++) begin
            term = (term * x) >>> 30;
            term = (term * x) >>> 30;
            term = -term / longint'((2 * n) * (2 * n + 1));
            sum  = sum + term;
        end
        return int'((sum * longint'(amp) + 64'sd536870912) >>> 30);
    endfunction

endpackage

// File: rtl/nco_phase.sv
module nco_phase
    import nco_pkg::*;
#(
    parameter int unsigned       PW        = 32,
    parameter int unsigned       LB        = 12,
    parameter bit                DITHER_ON = 1'b1,
    parameter logic [LFSR_W-1:0] SEED      = 32'h1ACE_B00C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [PW-1:0]     phase_inc,
    output logic [LB-1:0]     addr_q,
    output logic [LFSR_W-1:0] lfsr_q
);

    localparam int unsigned DTH_W = PW - LB;

    logic [PW-1:0] acc_q;
    logic [PW-1:0] dith;

    generate
        if (DITHER_ON) begin : g_dither
            assign dith = {{LB{1'b0}}, lfsr_q[DTH_W-1:0]};
        end else begin : g_plain
            assign dith = '0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            lfsr_q <= SEED;
            addr_q <= '0;
        end else if (en) begin
            addr_q <= LB'((acc_q + dith) >> DTH_W);
            acc_q  <= acc_q + phase_inc;
            lfsr_q <= lfsr_step(lfsr_q);
        end
    end

endmodule

// File: rtl/nco_sincos.sv
module nco_sincos
    import nco_pkg::*;
#(
    parameter int unsigned LB = 12,
    parameter int unsigned DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [LB-1:0]        addr,
    output logic signed [DW-1:0] cos_q,
    output logic signed [DW-1:0] sin_q
);

    localparam int unsigned IW  = LB - 2;
    localparam int unsigned QD  = 1 << IW;
    localparam int          AMP = (1 << (DW - 1)) - 1;

    logic signed [DW-1:0] rom [QD];

    for (genvar k = 0; k < QD; k++) begin : g_rom
        localparam int VAL = qsine(k, LB, AMP);
        assign rom[k] = DW'(VAL);
    end

    quad_e                quad;
    logic [IW-1:0]        idx;
    logic [IW-1:0]        idx_n;
    logic signed [DW-1:0] t_dir;
    logic signed [DW-1:0] t_mir;
    logic signed [DW-1:0] cos_c;
    logic signed [DW-1:0] sin_c;

    assign quad  = quad_e'(addr[LB-1 -: 2]);
    assign idx   = addr[IW-1:0];
    assign idx_n = ~idx;
    assign t_dir = rom[idx];
    assign t_mir = rom[idx_n];

    always_comb begin
        unique case (quad)
            QD_FIRST:  begin sin_c = t_dir;  cos_c = t_mir;  end
            QD_SECOND: begin sin_c = t_mir;  cos_c = -t_dir; end
            QD_THIRD:  begin sin_c = -t_dir; cos_c = -t_mir; end
            QD_FOURTH: begin sin_c = -t_mir; cos_c = t_dir;  end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cos_q <= '0;
            sin_q <= '0;
        end else if (en) begin
            cos_q <= cos_c;
            sin_q <= sin_c;
        end
    end

endmodule

// File: rtl/nco_cmix.sv
module nco_cmix #(
    parameter int unsigned DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 vld_in,
    input  logic signed [DW-1:0] i_s,
    input  logic signed [DW-1:0] q_s,
    input  logic signed [DW-1:0] cos_s,
    input  logic signed [DW-1:0] sin_s,
    output logic signed [DW-1:0] i_out,
    output logic signed [DW-1:0] q_out,
    output logic                 out_valid
);

    localparam int unsigned PRW = 2 * DW;
    localparam int unsigned SMW = PRW + 1;
    localparam logic signed [SMW-1:0] HALF  = {{(SMW-DW+1){1'b0}}, 1'b1, {(DW-2){1'b0}}};
    localparam logic signed [SMW-1:0] MAX_S = (SMW'(1) << (DW - 1)) - SMW'(1);
    localparam logic signed [SMW-1:0] MIN_S = -(SMW'(1) << (DW - 1));

    logic signed [PRW-1:0] p_ic, p_qs, p_qc, p_is;
    logic                  v3;
    logic signed [SMW-1:0] sum_i, sum_q, rnd_i, rnd_q;

    function automatic logic signed [DW-1:0] clip(input logic signed [SMW-1:0] v);
        if (v > MAX_S)      return DW'(MAX_S);
        else if (v < MIN_S) return DW'(MIN_S);
        else                return DW'(v);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_ic <= '0;
            p_qs <= '0;
            p_qc <= '0;
            p_is <= '0;
            v3   <= 1'b0;
        end else if (en) begin
            p_ic <= i_s * cos_s;
            p_qs <= q_s * sin_s;
            p_qc <= q_s * cos_s;
            p_is <= i_s * sin_s;
            v3   <= vld_in;
        end
    end

    assign sum_i = $signed({p_ic[PRW-1], p_ic}) + $signed({p_qs[PRW-1], p_qs});
    assign sum_q = $signed({p_qc[PRW-1], p_qc}) - $signed({p_is[PRW-1], p_is});
    assign rnd_i = (sum_i + HALF) >>> (DW - 1);
    assign rnd_q = (sum_q + HALF) >>> (DW - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_out     <= '0;
            q_out     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= en & v3;
            if (en) begin
                i_out <= clip(rnd_i);
                q_out <= clip(rnd_q);
            end
        end
    end

endmodule

// File: rtl/nco_mixer.sv
module nco_mixer
    import nco_pkg::*;
#(
    parameter int unsigned       DW        = 16,
    parameter int unsigned       PW        = 32,
    parameter int unsigned       LUT_BITS  = 12,
    parameter bit                DITHER_ON = 1'b1,
    parameter logic [LFSR_W-1:0] SEED      = 32'h1ACE_B00C
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [PW-1:0]        phase_inc,
    input  logic signed [DW-1:0] i_in,
    input  logic signed [DW-1:0] q_in,
    output logic signed [DW-1:0] i_out,
    output logic signed [DW-1:0] q_out,
    output logic                 out_valid
);

    logic [LUT_BITS-1:0]  addr_w;
    logic [LFSR_W-1:0]    lfsr_w;
    logic signed [DW-1:0] cos_w, sin_w;
    logic signed [DW-1:0] i_d1, q_d1, i_d2, q_d2;
    logic                 v1, v2;

    nco_phase #(
        .PW(PW), .LB(LUT_BITS), .DITHER_ON(DITHER_ON), .SEED(SEED)
    ) u_phase (
        .clk(clk), .rst_n(rst_n), .en(en), .phase_inc(phase_inc),
        .addr_q(addr_w), .lfsr_q(lfsr_w)
    );

    nco_sincos #(
        .LB(LUT_BITS), .DW(DW)
    ) u_sincos (
        .clk(clk), .rst_n(rst_n), .en(en), .addr(addr_w),
        .cos_q(cos_w), .sin_q(sin_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_d1 <= '0;
            q_d1 <= '0;
            i_d2 <= '0;
            q_d2 <= '0;
            v1   <= 1'b0;
            v2   <= 1'b0;
        end else if (en) begin
            i_d1 <= i_in;
            q_d1 <= q_in;
            i_d2 <= i_d1;
            q_d2 <= q_d1;
            v1   <= 1'b1;
            v2   <= v1;
        end
    end

    nco_cmix #(
        .DW(DW)
    ) u_cmix (
        .clk(clk), .rst_n(rst_n), .en(en), .vld_in(v2),
        .i_s(i_d2), .q_s(q_d2), .cos_s(cos_w), .sin_s(sin_w),
        .i_out(i_out), .q_out(q_out), .out_valid(out_valid)
    );

endmodule

// File: rtl/nco_mixer_chk.sv
module nco_mixer_chk #(
    parameter int unsigned DW     = 16,
    parameter int unsigned LFSR_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 en,
    input logic                 out_valid,
    input logic signed [DW-1:0] i_out,
    input logic signed [DW-1:0] q_out,
    input logic [LFSR_W-1:0]    lfsr
);

    logic [2:0] fill;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     fill <= 3'd0;
        else if (en && fill != 3'd4)    fill <= fill + 3'd1;
    end

    // R8
    valid_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> fill == 3'd4);

    // R8
    valid_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(en));

    // R8
    valid_streams_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && en) |=> out_valid);

    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(i_out) && $stable(q_out) && !out_valid));

    // R7
    lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(lfsr));

    // R3
    lfsr_alive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != '0);

endmodule

bind nco_mixer nco_mixer_chk #(.DW(DW), .LFSR_W(LFSR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .out_valid(out_valid),
    .i_out(i_out), .q_out(q_out), .lfsr(lfsr_w)
);

// File: tb/test_nco_mixer.sv
`timescale 1ns/1ps
module test_nco_mixer;

    localparam int          LB     = 12;
    localparam bit          DTH    = 1'b1;
    localparam logic [31:0] SEED_V = 32'h1ACE_B00C;
    localparam real         PI     = 3.14159265358979;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               en = 1'b0;
    logic [31:0]        phase_inc = '0;
    logic signed [15:0] i_in = '0;
    logic signed [15:0] q_in = '0;
    logic signed [15:0] i_out, q_out;
    logic               out_valid;

    always #2 clk = ~clk;

    nco_mixer #(
        .DW(16), .PW(32), .LUT_BITS(LB), .DITHER_ON(DTH), .SEED(SEED_V)
    ) i_nco_mixer (
        .clk(clk), .rst_n(rst_n), .en(en), .phase_inc(phase_inc),
        .i_in(i_in), .q_in(q_in), .i_out(i_out), .q_out(q_out),
        .out_valid(out_valid)
    );

    int    total = 0;
    int    bad = 0;
    string tag = "R1";
    bit    done = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint clip16(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // behavioural reference
    logic [31:0] m_acc, m_lfsr, m_ph;
    int          m_cnt = 0;
    bit          m_en_last = 1'b0;
    bit          m_valid_exp = 1'b0;
    longint      m_c, m_s, m_ei, m_eq;
    int          m_a;
    real         m_th;
    longint      exp_i_q[$];
    longint      exp_q_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = '0;
            m_lfsr = SEED_V;
            m_cnt = 0;
            exp_i_q.delete();
            exp_q_q.delete();
            m_en_last = 1'b0;
            m_valid_exp = 1'b0;
        end else begin
            m_en_last = en;
            if (en) begin
                m_ph = m_acc + (DTH ? (m_lfsr & ((32'h1 << (32 - LB)) - 32'h1)) : 32'h0);
                m_a  = int'(m_ph >> (32 - LB));
                m_th = 2.0 * PI * (real'(m_a) + 0.5) / real'(1 << LB);
                m_c  = longint'($rtoi($floor(32767.0 * $cos(m_th) + 0.5)));
                m_s  = longint'($rtoi($floor(32767.0 * $sin(m_th) + 0.5)));
                m_ei = (longint'(i_in) * m_c + longint'(q_in) * m_s + 16384) >>> 15;
                m_eq = (longint'(q_in) * m_c - longint'(i_in) * m_s + 16384) >>> 15;
                exp_i_q.push_back(clip16(m_ei));
                exp_q_q.push_back(clip16(m_eq));
                m_acc  = m_acc + phase_inc;
                m_lfsr = (m_lfsr >> 1) ^ (m_lfsr[0] ? 32'h8020_0003 : 32'h0);
                if (m_cnt < 4) m_cnt++;
            end
            m_valid_exp = en && (m_cnt >= 4);
        end
    end

    logic signed [15:0] prev_i = '0;
    logic signed [15:0] prev_q = '0;
    longint             want_i, want_q, d_i, d_q;

    always @(posedge clk) begin
        #1;
        if (!done) begin
            if (!rst_n) begin
                check(i_out == 0 && q_out == 0 && !out_valid, "R1 reset outputs",
                      longint'(i_out) + longint'(q_out) + longint'(out_valid), 0);
            end else begin
                check(out_valid == m_valid_exp, "R8 valid timing",
                      longint'(out_valid), longint'(m_valid_exp));
                if (!m_en_last) begin
                    check(i_out == prev_i, "R7 hold i_out", i_out, prev_i);
                    check(q_out == prev_q, "R7 hold q_out", q_out, prev_q);
                end
                if (out_valid) begin
                    if (exp_i_q.size() < 4) begin
                        check(1'b0, "R8 output before pipeline fill", exp_i_q.size(), 4);
                    end else begin
                        want_i = exp_i_q.pop_front();
                        want_q = exp_q_q.pop_front();
                        d_i = longint'(i_out) - want_i;
                        d_q = longint'(q_out) - want_q;
                        if (d_i < 0) d_i = -d_i;
                        if (d_q < 0) d_q = -d_q;
                        check(d_i <= 3, {tag, " i_out"}, i_out, want_i);
                        check(d_q <= 3, {tag, " q_out"}, q_out, want_q);
                    end
                end
            end
        end
        prev_i = i_out;
        prev_q = q_out;
    end

    task automatic drive(input bit e, input logic [31:0] inc,
                         input logic signed [15:0] iv, input logic signed [15:0] qv);
        @(negedge clk);
        en = e;
        phase_inc = inc;
        i_in = iv;
        q_in = qv;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 60000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        // R1: reset held
        tag = "R1";
        repeat (4) drive(1'b1, 32'h0, 16'sd1000, 16'sd1000);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: saturation at phase near zero
        tag = "R9";
        repeat (8) drive(1'b1, 32'h0, 16'sd32767, 16'sd32767);
        repeat (8) drive(1'b1, 32'h0, -16'sd32768, -16'sd32768);

        // R6: real-only input
        tag = "R6";
        for (int n = 0; n < 40; n++) drive(1'b1, 32'h0123_4567, 16'($urandom), 16'sd0);

        // R4: full-scale tone sweeps all quadrants
        tag = "R4";
        for (int n = 0; n < 200; n++) drive(1'b1, 32'd116080197, 16'sd32767, 16'sd0);

        // R2: increment changes every clock
        tag = "R2";
        for (int n = 0; n < 300; n++) drive(1'b1, $urandom, 16'($urandom), 16'($urandom));

        // R5: complex mixing, fixed step
        tag = "R5";
        for (int n = 0; n < 300; n++) drive(1'b1, 32'hA5A5_1234, 16'($urandom), 16'($urandom));

        // R7: irregular enable
        tag = "R7";
        for (int n = 0; n < 300; n++)
            drive(1'($urandom % 2), $urandom, 16'($urandom), 16'($urandom));

        // R1 and R3: reset again, then slow phase where dither decides boundaries
        tag = "R1";
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) drive(1'b0, 32'h0, 16'sd0, 16'sd0);
        @(negedge clk);
        rst_n = 1'b1;
        tag = "R3";
        for (int n = 0; n < 400; n++) drive(1'b1, 32'h0000_4000, 16'sd32767, 16'sd0);

        repeat (8) drive(1'b0, 32'h0, 16'sd0, 16'sd0);
        finish_run();
    end

endmodule